// File: doc/BRIEF.md
# Cache-as-RAM Address Mapper

This block decides whether a physical address falls inside the fixed window that is reserved for on-chip scratch RAM. That RAM is 8 KB, built from two 4 KB halves of the operand cache. For an address inside the window it returns a 13-bit offset into the RAM. The upper offset bit picks the half. The lower twelve bits are the byte position within a 4 KB half.

Two configuration bits control the mapping, and both are cleared by reset. The first enables RAM mode. The second is the index mode, and it chooses which address bit selects the half: a low bit (13) or a high bit (25). The window is much larger than 8 KB, so every address in it lands on some RAM location, and the 8 KB repeats across the whole window. The pattern of the repeats depends on the index mode.

Address beats enter through a valid/ready stream, and results leave through a second valid/ready stream. A single output register sits between the two streams. A beat is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high while the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new beat is accepted. The configuration port is plain: a one-cycle write strobe with the two mode bits.

Top module: `cram_mapper`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and RAM mode is disabled, so a beat in the window returns `out_hit` = 0.
- R2: With RAM mode enabled, a beat hits exactly when its address is at least 0x1C000000 and below 0x20000000. Addresses 0x1BFFFFFF and 0x20000000 miss. Addresses 0x1C000000 and 0x1FFFFFFF hit.
- R3: With index mode 0, `out_offset[12]` equals address bit 13 on a hit. Address bit 25 has no effect on the offset.
- R4: With index mode 1, `out_offset[12]` equals address bit 25 on a hit. Address bit 13 has no effect on the offset.
- R5: On a hit, `out_offset[11:0]` equals address bits 11:0.
- R6: While RAM mode is disabled, no address misses the mapping test less than any other: every beat returns `out_hit` = 0.
- R7: On a miss, `out_offset` is 0.
- R8: The result of a beat accepted at clock edge N is presented with `out_valid` = 1 after edge N.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_hit` and `out_offset` stay stable, and `in_ready` is 0.
- R10: A configuration write (`cfg_we` = 1) takes effect at the edge where it is sampled. A beat accepted at that same edge still uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the mode bits |
| cfg_ram_en | input | 1 | RAM mode enable value to load |
| cfg_idx_hi | input | 1 | Index mode value to load (1 = high select bit) |
| in_valid | input | 1 | Address beat valid |
| in_ready | output | 1 | Mapper can accept a beat |
| in_addr | input | 32 | Physical address of the beat |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_hit | output | 1 | Address maps into the RAM |
| out_offset | output | 13 | RAM byte offset (0 on a miss) |

## Verification
The mode register is hidden state, so an error in it can only appear one beat later, as a wrong hit decision or a wrong upper offset bit. The tests therefore choose addresses in which bits 13 and 25 differ, so that a wrong index mode changes `out_offset[12]` on the very next result. An error in the output register appears in a different way: the held result changes, or a second beat slips in, during the first stalled cycle. The tests therefore check the held values on each stalled cycle, and do not wait for the stall to end.

// File: rtl/cram_pkg.sv
package cram_pkg;
  typedef struct packed {
    logic ram_en;
    logic idx_hi;
  } cram_mode_t;

  localparam int unsigned CRAM_ADDR_W = 32;
  localparam int unsigned CRAM_PAGE_BITS = 12;
endpackage

// File: rtl/cram_mode_reg.sv
module cram_mode_reg
  import cram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       ram_en_d,
  input  logic       idx_hi_d,
  output cram_mode_t mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (we) begin
      mode_q.ram_en <= ram_en_d;
      mode_q.idx_hi <= idx_hi_d;
    end
  end
endmodule

// File: rtl/cram_window_dec.sv
module cram_window_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h1C00_0000,
  parameter logic [ADDR_W-1:0] LIMIT = 32'h2000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);
  // Lower bound inclusive, upper bound exclusive.
  always_comb begin
    in_win = (addr >= BASE) && (addr < LIMIT);
  end
endmodule

// File: rtl/cram_offset_gen.sv
module cram_offset_gen #(
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned OFF_W = PAGE_BITS + 1
) (
  input  logic                 lo_sel,
  input  logic                 hi_sel,
  input  logic                 idx_hi,
  input  logic [PAGE_BITS-1:0] page_off,
  output logic [OFF_W-1:0]     offset
);
  logic half;

  always_comb begin
    half   = idx_hi ? hi_sel : lo_sel;
    offset = {half, page_off};
  end
endmodule

// File: rtl/cram_mapper.sv
module cram_mapper
  import cram_pkg::*;
#(
  parameter int unsigned ADDR_W = CRAM_ADDR_W,
  parameter int unsigned PAGE_BITS = CRAM_PAGE_BITS,
  parameter int unsigned LO_SEL_BIT = 13,
  parameter int unsigned HI_SEL_BIT = 25,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1C00_0000,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 32'h2000_0000,
  localparam int unsigned OFF_W = PAGE_BITS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_ram_en,
  input  logic              cfg_idx_hi,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [OFF_W-1:0]  out_offset
);
  cram_mode_t mode_q;
  logic in_win;
  logic [OFF_W-1:0] raw_off;
  logic take;
  logic hit_d;

  cram_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .ram_en_d (cfg_ram_en),
    .idx_hi_d (cfg_idx_hi),
    .mode_q   (mode_q)
  );

  cram_window_dec #(
    .ADDR_W (ADDR_W),
    .BASE   (WIN_BASE),
    .LIMIT  (WIN_LIMIT)
  ) u_win (
    .addr   (in_addr),
    .in_win (in_win)
  );

  cram_offset_gen #(
    .PAGE_BITS (PAGE_BITS)
  ) u_off (
    .lo_sel   (in_addr[LO_SEL_BIT]),
    .hi_sel   (in_addr[HI_SEL_BIT]),
    .idx_hi   (mode_q.idx_hi),
    .page_off (in_addr[PAGE_BITS-1:0]),
    .offset   (raw_off)
  );

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
    hit_d    = in_win && mode_q.ram_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_offset <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_hit    <= hit_d;
      out_offset <= hit_d ? raw_off : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_offset)));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_offset == '0));

  // R5
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (!out_hit || out_offset[PAGE_BITS-1:0] == $past(in_addr[PAGE_BITS-1:0])));

  // R6
  disabled_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mode_q.ram_en) |=> !out_hit);
endmodule

// File: tb/cram_mapper_tb.sv
module cram_mapper_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_ram_en = 1'b0, cfg_idx_hi = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_addr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_hit;
  logic [12:0] out_offset;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cram_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ram_en(cfg_ram_en),
    .cfg_idx_hi(cfg_idx_hi), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_offset(out_offset)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic set_mode(input logic en, input logic hi);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ram_en = en; cfg_idx_hi = hi;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic beat(input string req, input logic [31:0] a, input logic hit, input logic [12:0] off);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " hit"}, {31'd0, out_hit}, {31'd0, hit});
    chk({req, " offset"}, {19'd0, out_offset}, {19'd0, off});
  endtask

  task automatic t_reset();
    // R1: idle outputs, mapping disabled
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    beat("R1", 32'h1C00_0100, 1'b0, 13'h0);
    // R6 and R7: disabled window miss with zero offset
    beat("R6 R7", 32'h1E00_2ABC, 1'b0, 13'h0);
  endtask

  task automatic t_low_index();
    set_mode(1'b1, 1'b0);
    beat("R3 R5", 32'h1C00_2ABC, 1'b1, 13'h1ABC);
    beat("R3", 32'h1C00_0123, 1'b1, 13'h0123);
    beat("R3 alias", 32'h1DFF_E456, 1'b1, 13'h1456);
    beat("R3 bit25 ignored", 32'h1E00_0ABC, 1'b1, 13'h0ABC);
  endtask

  task automatic t_high_index();
    set_mode(1'b1, 1'b1);
    beat("R4", 32'h1E00_0ABC, 1'b1, 13'h1ABC);
    beat("R4 bit13 ignored", 32'h1C00_2ABC, 1'b1, 13'h0ABC);
  endtask

  task automatic t_bounds();
    beat("R2 below", 32'h1BFF_FFFF, 1'b0, 13'h0);
    beat("R2 limit", 32'h2000_0000, 1'b0, 13'h0);
    beat("R2 base", 32'h1C00_0000, 1'b1, 13'h0000);
    beat("R2 top", 32'h1FFF_FFFF, 1'b1, 13'h1FFF);
    beat("R7 far", 32'h8000_0ABC, 1'b0, 13'h0);
  endtask

  task automatic t_backpressure();
    set_mode(1'b1, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 32'h1C00_2001;
    @(negedge clk);
    in_addr = 32'h1C00_0777;
    chk("R8 stall valid", {31'd0, out_valid}, 32'd1);
    chk("R9 in_ready low", {31'd0, in_ready}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 held offset", {19'd0, out_offset}, 32'h1001);
      chk("R9 held hit", {31'd0, out_hit}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next beat", {19'd0, out_offset}, 32'h0777);
    @(negedge clk);
    chk("R8 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_mode_timing();
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h1C00_0042;
    cfg_we = 1'b1; cfg_ram_en = 1'b0; cfg_idx_hi = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    chk("R10 old mode hit", {31'd0, out_hit}, 32'd1);
    chk("R10 old mode offset", {19'd0, out_offset}, 32'h0042);
    beat("R10 new mode", 32'h1C00_0042, 1'b0, 13'h0);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_index();
    t_high_index();
    t_bounds();
    t_backpressure();
    t_mode_timing();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule